// File: doc/BRIEF.md
# I2C Master SCL Phase Generator

This block paces the SCL clock of an I2C master. A 32-bit timing word gives a prescaler value and four counts. The kernel clock is divided into a base tick, and the tick is used to time four intervals: the SCL low period, the SCL high period, the data hold delay after SCL falls and the data setup delay before SCL rises. The block does not move SDA itself. It raises a one-cycle strobe when the byte-level logic may change SDA, and another in the last cycle of the low phase, just before it lets SCL go.

Each SCL period starts with a low phase, in which the block asks for SCL to be driven low. The hold delay runs first. The setup delay starts where the hold delay ends. The low phase ends when both the low count and the setup delay have run out, whichever is later. After release the block waits until the synchronised SCL line is actually high. Only then does it count the high period, so a slave that stretches the clock lengthens the period. Clearing the enable releases SCL and returns every counter to zero.

One prescaled tick is P = PRESC+1 kernel cycles.

Top module: `scl_phase_gen`

## Requirements
- R1: While `enable` is low, `scl_drive_low`, `sda_change` and `scl_rise_ok` are 0 one cycle after `enable` was sampled low and stay 0. The cycle after `enable` is first sampled high, `scl_drive_low` is 1.
- R2: In each low phase, `sda_change` pulses exactly once, in cycle SDADEL*P. Cycle 0 is the first cycle in which `scl_drive_low` is 1, so SDADEL=0 gives the pulse in cycle 0.
- R3: When SCLL+1 is at least SDADEL+SCLDEL+1, `scl_drive_low` stays 1 for exactly (SCLL+1)*P cycles.
- R4: When SDADEL+SCLDEL+1 exceeds SCLL+1, the setup delay lengthens the low phase to exactly (SDADEL+SCLDEL+1)*P cycles.
- R5: `scl_rise_ok` pulses exactly once per low phase, in its last cycle, and `scl_drive_low` falls in the next cycle.
- R6: After release, `scl_drive_low` returns to 1 after exactly SYNC_STAGES+1+(SCLH+1)*P cycles, counted from the first cycle in which `scl_in` is high.
- R7: While `scl_in` stays low after release, `scl_drive_low` stays 0. Holding `scl_in` low for S extra cycles lengthens the high side of the period by exactly S cycles.
- R8: The fields of `timing_word` are decoded as follows: SCLL in bits 7:0, SCLH in 15:8, SDADEL in 19:16, SCLDEL in 23:20 and PRESC in 31:28. Bits 27:24 are ignored.
- R9: The tick period P is PRESC+1 kernel cycles, for PRESC from 0 (P=1) to 15 (P=16), and every interval scales with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases SCL and clears all counters |
| timing_word | input | 32 | Prescaler and the four interval counts (held stable while enabled) |
| scl_in | input | 1 | SCL line as seen on the bus (asynchronous) |
| scl_drive_low | output | 1 | Request to pull SCL low |
| sda_change | output | 1 | One-cycle strobe: SDA may change now |
| scl_rise_ok | output | 1 | One-cycle strobe in the last cycle of the low phase |

## Verification
The end of the hold delay and the end of the low phase can fall in the same kernel cycle. This happens when P=1, SCLDEL=0 and the hold delay dominates the low count. In that case the setup delay must be judged complete in the very cycle in which it begins. The bench provokes this with P=1, SCLL=0, SDADEL=3 and SCLDEL=0. It requires `sda_change` and `scl_rise_ok` to pulse together in cycle 3 of a four-cycle low phase. The case with no hold delay at all (SDADEL=0) is run next to it.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int PRESC_W = 4;
  localparam int PER_W   = 8;
  localparam int DLY_W   = 4;
  localparam int RSV_W   = 4;
  localparam int DCNT_W  = DLY_W + 1;

  typedef enum logic [1:0] {
    PH_OFF     = 2'd0,
    PH_LOW     = 2'd1,
    PH_WAIT_HI = 2'd2,
    PH_HIGH    = 2'd3
  } phase_e;

  typedef enum logic {
    SUB_HOLD  = 1'b0,
    SUB_SETUP = 1'b1
  } lowsub_e;

  // Member order reproduces the bit layout of the timing word, MSB first.
  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [RSV_W-1:0]   rsvd;
    logic [DLY_W-1:0]   setup_len;
    logic [DLY_W-1:0]   hold_len;
    logic [PER_W-1:0]   high_len;
    logic [PER_W-1:0]   low_len;
  } timing_t;
endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] div,
  output logic         tick,
  output logic         phase0
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick   = (cnt_q == div);
  assign phase0 = (cnt_q == '0);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: a tick on a divider above zero is never followed straight by another
  p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div != '0) && !restart) |=> (!tick || div == '0));
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_low,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q, sr_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sr_d = force_low ? 1'b0 : din;
    end else begin : g_chain
      always_comb sr_d = force_low ? '0 : {sr_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/scl_lowphase_ctl.sv
module scl_lowphase_ctl
  import scl_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             phase0,
  input  logic [DLY_W-1:0] hold_len,
  input  logic [DLY_W-1:0] setup_len,
  output logic             sda_go,
  output logic             setup_met
);
  lowsub_e             sub_q, sub_d;
  logic [DCNT_W-1:0]   dcnt_q, dcnt_d;

  assign sda_go = active && (sub_q == SUB_HOLD) && phase0 &&
                  (dcnt_q == {1'b0, hold_len});

  // A zero setup count is met in the cycle the hold ends if a tick lands there.
  assign setup_met = active &&
                     (((sub_q == SUB_SETUP) && (dcnt_q >= {1'b0, setup_len})) ||
                      (sda_go && (setup_len == '0)));

  always_comb begin
    sub_d  = sub_q;
    dcnt_d = dcnt_q;
    if (!active) begin
      sub_d  = SUB_HOLD;
      dcnt_d = '0;
    end else if (sda_go) begin
      sub_d  = SUB_SETUP;
      dcnt_d = tick ? DCNT_W'(1) : '0;
    end else if (tick && (dcnt_q != '1)) begin
      dcnt_d = dcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= SUB_HOLD;
      dcnt_q <= '0;
    end else begin
      sub_q  <= sub_d;
      dcnt_q <= dcnt_d;
    end
  end

  // R2: the SDA strobe never repeats on the following cycle
  p_sda_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_go |=> !sda_go);
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] timing_word,
  input  logic        scl_in,
  output logic        scl_drive_low,
  output logic        sda_change,
  output logic        scl_rise_ok
);
  timing_t            tw;
  phase_e             state_q, state_d;
  logic [PER_W-1:0]   tcnt_q, tcnt_d;
  logic               tick, phase0, restart, line_hi, setup_met, in_low;

  assign tw      = timing_t'(timing_word);
  assign in_low  = enable && (state_q == PH_LOW);
  assign restart = (state_d != state_q);

  scl_tick_div #(.W(PRESC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(tw.presc),
    .tick(tick), .phase0(phase0));

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .force_low(scl_drive_low), .din(scl_in),
    .dout(line_hi));

  scl_lowphase_ctl u_lowctl (
    .clk(clk), .rst_n(rst_n), .active(in_low), .tick(tick), .phase0(phase0),
    .hold_len(tw.hold_len), .setup_len(tw.setup_len),
    .sda_go(sda_change), .setup_met(setup_met));

  assign scl_rise_ok = in_low && tick && (tcnt_q >= tw.low_len) && setup_met;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = PH_OFF;
    end else begin
      unique case (state_q)
        PH_OFF:     state_d = PH_LOW;
        PH_LOW:     if (scl_rise_ok) state_d = PH_WAIT_HI;
        PH_WAIT_HI: if (line_hi) state_d = PH_HIGH;
        PH_HIGH:    if (tick && (tcnt_q >= tw.high_len)) state_d = PH_LOW;
        default:    state_d = PH_OFF;
      endcase
    end
  end

  always_comb begin
    if (restart)                     tcnt_d = '0;
    else if (tick && tcnt_q != '1)   tcnt_d = tcnt_q + 1'b1;
    else                             tcnt_d = tcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_OFF;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
    end
  end

  assign scl_drive_low = (state_q == PH_LOW);

  // R1: a cleared enable releases SCL on the next cycle
  p_off_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_drive_low);

  // R5: SCL is let go only after a release strobe or a disable
  p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> ($past(scl_rise_ok) || !$past(enable)));

  // R7: no new low phase while the line has not been seen high
  p_stretch_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == PH_WAIT_HI && !line_hi) |=> !scl_drive_low);

  // R2: the SDA strobe only appears while SCL is driven low
  p_sda_in_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change |-> scl_drive_low);
endmodule

// File: tb/tb_scl_phase_gen.sv
`timescale 1ns/100ps
module tb_scl_phase_gen;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] timing_word = '0;
  logic        stretch_req = 1'b0;
  logic        scl_line;
  logic        scl_drive_low, sda_change, scl_rise_ok;
  int          n_tests = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  assign scl_line = ~scl_drive_low & ~stretch_req;

  scl_phase_gen #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .timing_word(timing_word),
    .scl_in(scl_line), .scl_drive_low(scl_drive_low),
    .sda_change(sda_change), .scl_rise_ok(scl_rise_ok));

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] mk_word(input int presc, input int scll, input int sclh,
                                          input int hold, input int setup);
    // R8: PRESC 31:28, reserved 27:24 filled with ones, SCLDEL 23:20, SDADEL 19:16, SCLH 15:8, SCLL 7:0
    return {presc[3:0], 4'hF, setup[3:0], hold[3:0], sclh[7:0], scll[7:0]};
  endfunction

  task automatic measure_low(input string req, input int exp_sda, input int exp_len);
    int c = 0, sda_at = -1, sda_n = 0, rel_at = -1, rel_n = 0;
    while (!scl_drive_low) @(negedge clk);
    while (scl_drive_low) begin
      if (sda_change) begin sda_n++; sda_at = c; end
      if (scl_rise_ok) begin rel_n++; rel_at = c; end
      c++;
      @(negedge clk);
    end
    check_eq({req, "/R3 R4"}, "low length", c, exp_len);
    check_eq({req, "/R2"}, "sda strobe cycle", sda_at, exp_sda);
    check_eq("R2", "sda strobe count", sda_n, 1);
    check_eq("R5", "release strobe cycle", rel_at, exp_len - 1);
    check_eq("R5", "release strobe count", rel_n, 1);
  endtask

  task automatic measure_high(input string req, input int exp_len, input int stretch);
    int n = 0;
    while (!scl_drive_low) begin
      n++;
      if (n == stretch + 1) stretch_req = 1'b0;
      @(negedge clk);
    end
    check_eq({req, "/R6"}, "released length", n, exp_len);
  endtask

  task automatic run_case(input string req, input int presc, input int scll, input int sclh,
                          input int hold, input int setup, input int stretch);
    int p, lo, hi;
    p  = presc + 1;
    lo = imax(scll + 1, hold + setup + 1) * p;
    hi = SYNC + 1 + (sclh + 1) * p;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    timing_word = mk_word(presc, scll, sclh, hold, setup);
    enable = 1'b1;
    @(negedge clk);
    check_eq("R1", "drive low after enable", int'(scl_drive_low), 1);
    measure_low(req, hold * p, lo);
    measure_high(req, hi, 0);
    if (stretch > 0) stretch_req = 1'b1;
    measure_low(req, hold * p, lo);
    measure_high({req, "/R7"}, hi + stretch, stretch);
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check_eq("R1", "reset drive", int'(scl_drive_low), 0);
    check_eq("R1", "reset sda strobe", int'(sda_change), 0);
    check_eq("R1", "reset release strobe", int'(scl_rise_ok), 0);
  endtask

  task automatic t_disable_mid;
    int bad = 0;
    timing_word = mk_word(1, 20, 4, 3, 2);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    check_eq("R1", "low phase under way", int'(scl_drive_low), 1);
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      if (scl_drive_low || sda_change || scl_rise_ok) bad++;
      @(negedge clk);
    end
    check_eq("R1", "outputs active while disabled", bad, 0);
  endtask

  task automatic t_hold_stretch;
    int lows = 0;
    timing_word = mk_word(0, 2, 2, 1, 0);
    stretch_req = 1'b1;
    enable = 1'b1;
    measure_low("R7", 1, 3);
    for (int i = 0; i < 40; i++) begin
      if (scl_drive_low) lows++;
      @(negedge clk);
    end
    check_eq("R7", "drive low while line held low", lows, 0);
    stretch_req = 1'b0;
    measure_high("R7", SYNC + 1 + 3, 0);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R3 basic", 0, 5, 3, 2, 1, 0);
    run_case("R9 div3", 2, 3, 2, 1, 0, 0);
    run_case("R4 setup", 1, 1, 4, 4, 5, 0);
    run_case("R2 collide", 0, 0, 1, 3, 0, 0);
    run_case("R2 nohold", 1, 2, 0, 0, 0, 0);
    run_case("R8 max", 15, 2, 1, 15, 15, 0);
    run_case("R7 stretch", 0, 5, 3, 2, 1, 10);
    t_disable_mid();
    t_hold_stretch();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule